// File: doc/BRIEF.md
# Programmable Reference Ratio Divider with Output Selector

The block takes a reference clock and divides it by one of sixteen ratios picked by a 4-bit code. The result is the comparison rate for a phase detector. Each divided period ends in a one-cycle comparison strobe. A square-ish comparison clock is also produced. Its high phase lasts floor(N/2) reference cycles and its low phase lasts the remaining ceil(N/2) cycles, so odd ratios such as 5 come out exactly.

The ratio set mixes powers of two with the 5·2^k series and a lone 24. For that reason the divider is a loadable down-counter stepped by a small state machine. It is not a binary prescaler chain. The states are `S_LOAD`, `S_HIGH` and `S_LOW`:
- `S_LOAD` is the reset state. It exits on the first clock edge (transition LOAD→HIGH), taking in the code.
- `S_HIGH` counts down the high phase, then moves on (transition HIGH→LOW).
- `S_LOW` counts down the low phase. Its last cycle is the terminal count (transition LOW→HIGH). On that cycle the strobe fires and the code present at that moment is loaded for the next period.

A ratio change therefore never cuts a period short.

A second path feeds an output pad that is shared between the reference and the comparison clock. A registered enable and a registered select choose between three cases:
- Pad off: the pad enable is low and the data is held at 0.
- The undivided reference.
- The comparison clock.

Both registers come out of reset at 1, so the pad carries the comparison clock from power-up.

Top module: `ref_ratio_divider`

## Requirements
- R1: Codes 0 to 7 (values of `ratio_code`) give a strobe period of 2, 4, 8, 16, 32, 64, 128 and 256 reference cycles respectively.
- R2: Codes 8 to 15 give a strobe period of 24, 5, 10, 20, 40, 80, 160 and 320 reference cycles respectively.
- R3: The comparison clock is high for floor(N/2) cycles and low for ceil(N/2) cycles of each period of N cycles. The strobe is high for exactly the last low cycle, and the comparison clock rises on the next edge.
- R4: A new code is taken only on the terminal-count cycle. A change made after that cycle leaves the running period at the old ratio and applies to the following one. A change present on the terminal cycle itself applies to the very next period.
- R5: With the registered enable at 0, `refcmp_oe` is 0 and `refcmp_out` is 0 whatever the select and the clocks do.
- R6: With enable 1 and select 0, `refcmp_out` equals the reference clock: 1 while it is high and 0 while it is low. `refcmp_oe` is 1.
- R7: With enable 1 and select 1, `refcmp_out` carries the comparison clock. It is 0 on the strobe cycle and 1 on the cycle after.
- R8: Enable and select are captured on each rising edge and act from that edge on. Both reset to 1, so during reset `refcmp_oe` is 1 and `refcmp_out` is the low comparison clock.
- R9: After reset is released, the comparison clock is high from the first edge. The first strobe appears in the N-th cycle after release, for the code applied at release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock, the divided signal |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 4 | Division ratio code |
| out_en | input | 1 | Pad output enable request |
| out_sel | input | 1 | Pad source: 0 reference, 1 comparison clock |
| cmp_stb | output | 1 | One-cycle strobe at each comparison period end |
| refcmp_out | output | 1 | Selected pad data |
| refcmp_oe | output | 1 | Tri-state pad drive enable |

## Verification
The two functions that can meet in one cycle are the terminal-count reload and a change of the ratio code. The bench sets a new code exactly on the sample where the strobe is seen, which is the terminal cycle. It expects the very next period to use the new ratio. One cycle later it changes the code again and expects the running period to finish at the old length before the newer ratio applies. Both outcomes are judged by counting reference cycles between successive strobes.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    localparam int CODE_W    = 4;
    localparam int RATIO_MAX = 320;
    localparam int CNT_W     = $clog2(RATIO_MAX + 1);

    typedef enum logic [1:0] {
        S_LOAD = 2'd0,
        S_HIGH = 2'd1,
        S_LOW  = 2'd2
    } div_state_e;
endpackage

// File: rtl/refdiv_ratio_dec.sv
module refdiv_ratio_dec
    import refdiv_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  ratio,
    output logic [CNT_W-1:0]  hi_len
);
    localparam int SH_W = CODE_W - 1;

    logic [SH_W-1:0] shift;

    always_comb begin
        shift = code[SH_W-1:0];
        if (!code[CODE_W-1]) begin
            ratio = CNT_W'(2) << shift;
        end else if (shift == '0) begin
            ratio = CNT_W'(24);
        end else begin
            ratio = CNT_W'(5) << (shift - SH_W'(1));
        end
        hi_len = ratio >> 1;
    end
endmodule

// File: rtl/refdiv_fsm.sv
module refdiv_fsm
    import refdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] new_ratio,
    input  logic [CNT_W-1:0] new_hi,
    output logic             cmp_clk,
    output logic             cmp_stb
);
    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] ratio_q, ratio_d;
    logic [CNT_W-1:0] act_lo;

    assign act_lo = ratio_q - (ratio_q >> 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_LOAD;
            cnt_q   <= '0;
            ratio_q <= CNT_W'(2);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ratio_q <= ratio_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q - CNT_W'(1);
        ratio_d = ratio_q;
        unique case (state_q)
            S_LOAD: begin
                state_d = S_HIGH;
                ratio_d = new_ratio;
                cnt_d   = new_hi - CNT_W'(1);
            end
            S_HIGH: begin
                if (cnt_q == '0) begin
                    state_d = S_LOW;
                    cnt_d   = act_lo - CNT_W'(1);
                end
            end
            S_LOW: begin
                if (cnt_q == '0) begin
                    state_d = S_HIGH;
                    ratio_d = new_ratio;
                    cnt_d   = new_hi - CNT_W'(1);
                end
            end
            default: begin
                state_d = S_LOAD;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        cmp_clk = (state_q == S_HIGH);
        cmp_stb = (state_q == S_LOW) && (cnt_q == '0);
    end

    AST_STB_THEN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_stb |=> $rose(cmp_clk)); // R3
    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_LOAD && !cmp_stb) |=> $stable(ratio_q)); // R4
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_LOAD) |-> (cnt_q < ratio_q)); // R1
    AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HIGH) |-> (ratio_q >= CNT_W'(2) && ratio_q <= CNT_W'(RATIO_MAX))); // R2
endmodule

// File: rtl/refdiv_outsel.sv
module refdiv_outsel (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    input  logic sel_in,
    input  logic cmp_clk,
    output logic pad_out,
    output logic pad_oe
);
    logic en_q, sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b1;
            sel_q <= 1'b1;
        end else begin
            en_q  <= en_in;
            sel_q <= sel_in;
        end
    end

    always_comb begin
        pad_oe  = en_q;
        pad_out = en_q ? (sel_q ? cmp_clk : clk) : 1'b0;
    end

    AST_OE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_oe) |-> !$past(en_in)); // R8
endmodule

// File: rtl/ref_ratio_divider.sv
module ref_ratio_divider
    import refdiv_pkg::*;
(
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic              out_en,
    input  logic              out_sel,
    output logic              cmp_stb,
    output logic              refcmp_out,
    output logic              refcmp_oe
);
    logic [CNT_W-1:0] dec_ratio;
    logic [CNT_W-1:0] dec_hi;
    logic             cmp_clk;

    refdiv_ratio_dec u_dec (
        .code   (ratio_code),
        .ratio  (dec_ratio),
        .hi_len (dec_hi)
    );

    refdiv_fsm u_fsm (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .new_ratio (dec_ratio),
        .new_hi    (dec_hi),
        .cmp_clk   (cmp_clk),
        .cmp_stb   (cmp_stb)
    );

    refdiv_outsel u_out (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .en_in   (out_en),
        .sel_in  (out_sel),
        .cmp_clk (cmp_clk),
        .pad_out (refcmp_out),
        .pad_oe  (refcmp_oe)
    );
endmodule

// File: tb/ref_ratio_divider_bench.sv
`timescale 1ns/1ps
module ref_ratio_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] code;
    logic       en, sel;
    logic       stb, pout, poe;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    ref_ratio_divider u_ref_ratio_divider (
        .clk_ref    (clk),
        .rst_n      (rst_n),
        .ratio_code (code),
        .out_en     (en),
        .out_sel    (sel),
        .cmp_stb    (stb),
        .refcmp_out (pout),
        .refcmp_oe  (poe)
    );

    function automatic int exp_ratio(input int c);
        if (c < 8) return 2 << c;
        if (c == 8) return 24;
        return 5 << (c - 9);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // sample point: 1 ns after a rising edge (reference clock high)
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_stb();
        for (int i = 0; i < 1000; i++) begin
            tick();
            if (stb) return;
        end
    endtask

    // counts cycles to the next strobe and high cycles of the pad on the way
    task automatic measure(output int n, output int hi);
        n = 0;
        hi = 0;
        for (int i = 0; i < 1000; i++) begin
            tick();
            n++;
            if (pout) hi++;
            if (stb) return;
        end
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        en = 1'b1; sel = 1'b1; code = 4'd9;
        tick(); tick();
        chk(poe == 1'b1, "R8 oe in reset", int'(poe), 1);
        chk(pout == 1'b0, "R8 out in reset", int'(pout), 0);
        chk(stb == 1'b0, "R8 stb in reset", int'(stb), 0);
        rst_n = 1'b1;
        tick();
        chk(pout == 1'b1, "R9 cmp high after first edge", int'(pout), 1);
        n = 1;
        while (!stb && n < 1000) begin
            tick();
            n++;
        end
        chk(n == 5, "R9 first strobe cycle", n, 5);
    endtask

    task automatic t_period(input int c);
        int n, hi;
        code = 4'(c);
        wait_stb();
        measure(n, hi);
        chk(n == exp_ratio(c), (c < 8) ? "R1 period" : "R2 period", n, exp_ratio(c));
        chk(hi == exp_ratio(c) / 2, "R3 high phase", hi, exp_ratio(c) / 2);
    endtask

    task automatic t_change();
        int n, hi;
        code = 4'd9;
        wait_stb();
        code = 4'd10;           // change on the terminal cycle itself
        measure(n, hi);
        chk(n == 10, "R4 change on terminal cycle", n, 10);
        tick();
        code = 4'd1;            // change one cycle into a period
        n = 1;
        while (!stb && n < 1000) begin
            tick();
            n++;
        end
        chk(n == 10, "R4 running period keeps old ratio", n, 10);
        measure(n, hi);
        chk(n == 4, "R4 new ratio next period", n, 4);
    endtask

    task automatic t_mux();
        code = 4'd11;
        sel = 1'b0;
        tick(); tick();
        for (int i = 0; i < 4; i++) begin
            chk(pout == 1'b1, "R6 ref high phase", int'(pout), 1);
            #2;
            chk(pout == 1'b0, "R6 ref low phase", int'(pout), 0);
            chk(poe == 1'b1, "R6 oe", int'(poe), 1);
            tick();
        end
        sel = 1'b1;
        tick();
        wait_stb();
        chk(pout == 1'b0, "R7 cmp low on strobe", int'(pout), 0);
        tick();
        chk(pout == 1'b1, "R7 cmp high after strobe", int'(pout), 1);
        en = 1'b0;
        chk(poe == 1'b1, "R8 enable not yet captured", int'(poe), 1);
        tick();
        for (int i = 0; i < 24; i++) begin
            chk(poe == 1'b0 && pout == 1'b0, "R5 off with select 1", int'({poe, pout}), 0);
            tick();
        end
        sel = 1'b0;
        tick();
        for (int i = 0; i < 4; i++) begin
            chk(poe == 1'b0 && pout == 1'b0, "R5 off with select 0 clk high", int'({poe, pout}), 0);
            #2;
            chk(pout == 1'b0, "R5 off with select 0 clk low", int'(pout), 0);
            tick();
        end
        en = 1'b1; sel = 1'b1;
        tick();
        chk(poe == 1'b1, "R8 enable captured", int'(poe), 1);
    endtask

    initial begin
        t_reset();
        for (int c = 0; c < 16; c++) t_period(c);
        t_change();
        t_mux();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule